// File: doc/BRIEF.md
# Vectored Interrupt Priority Acceptance Unit

This unit sits between the interrupt sources of a processor core and the core itself. Two request ports, one for local sources and one for external sources, each present an 8-bit vector. Accepted vectors are kept in a 256-bit pending register. A small dispatch state machine picks the highest pending vector. It offers that vector to the core when the vector's priority class beats both the task-priority threshold and the class of the vector now in service. The priority class is the upper nibble of the vector.

When the core acknowledges, the vector moves from the pending register to a 256-bit in-service register, which records nesting. An end-of-interrupt write retires the highest vector in service. A small register port lets software read the pending and in-service registers and the task-priority value. The same port lets software write the task priority and signal end of interrupt.

Each class holds at most one pending vector, while another vector of the same class may be in service. A further distinct request for a class whose pending slot is full is dropped and reported on an overflow pulse. The dispatch state machine has two states. In ST_SCAN nothing is offered; it moves to ST_OFFER when an eligible candidate exists. In ST_OFFER the latched vector is presented; it returns to ST_SCAN on the acknowledge.

Top module: `ipa_accept_top`

## Requirements
- R1: A request whose vector is below 32 is discarded: no pending bit is set, nothing is offered and no overflow pulse is raised.
- R2: A valid request for vector v of 32 or more sets pending bit v at the next clock edge. A request for a vector that is already pending merges into it without an overflow.
- R3: Each class holds at most one pending vector. A distinct vector requested for a class that already holds one is dropped, and req_overflow is high for exactly the cycle after that edge. When both ports request distinct vectors of one free class in the same cycle, the local vector is kept and the external one is dropped.
- R4: int_req rises, one edge after the pending register shows a candidate, with int_vector equal to the highest pending vector. This happens only when that vector's class (bits 7:4) is strictly greater than the task-priority class and strictly greater than the class of the highest in-service vector; the in-service class counts as 0 when nothing is in service.
- R5: A task-priority class of 15 blocks every offer.
- R6: While int_req is high and int_ack low, int_vector holds its value. At the edge where int_req and int_ack are both high, the pending bit clears, the in-service bit sets, and int_req is low in the next cycle. int_ack has no effect while int_req is low.
- R7: An end-of-interrupt write clears only the highest set in-service bit. With the in-service register empty it changes nothing.
- R8: Register map, byte offsets on reg_addr. Task priority is at 0x080, read/write, bits 7:4 being the class. A write of any data to 0x0B0 is an end of interrupt. In-service word n, covering vectors 32n to 32n+31 with vector 32n at bit 0, reads at 0x100+0x10*n. Pending word n reads at 0x200+0x10*n. Every other address reads 0, and writes to the word addresses are ignored.
- R9: After reset the pending register, the in-service register and the task priority are 0, and int_req and req_overflow are low.
- R10: Nesting: while a vector is in service, a pending vector of a higher class is offered. A pending vector of the same or a lower class waits until end of interrupt has retired every in-service vector of its class or above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| loc_req_valid | input | 1 | Local request strobe |
| loc_req_vector | input | 8 | Local request vector |
| ext_req_valid | input | 1 | External request strobe |
| ext_req_vector | input | 8 | External request vector |
| int_req | output | 1 | Interrupt offered to the core |
| int_vector | output | 8 | Vector offered |
| int_ack | input | 1 | Core acknowledge of the offered vector |
| reg_addr | input | 12 | Register byte offset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| req_overflow | output | 1 | One-cycle pulse after a request was dropped |

## Verification
The hardest state to reach from the ports is a class with its pending slot full while a vector of that class, or of a higher one, is already in service, together with further requests aimed at the same class. Only in that state do overflow, merging and nested retirement interact. The stimulus writes the task priority to class 15 so that requests pile up undelivered. It fills and overflows classes from both ports, including same-cycle pairs. It then lowers the threshold and drains, checking offer order and end-of-interrupt order. Separate exhaustive sweeps cover every vector alone and every pairing of threshold class with request class.

// File: rtl/ipa_pkg.sv
`timescale 1ns/1ps
package ipa_pkg;
    typedef enum logic {
        ST_SCAN  = 1'b0,
        ST_OFFER = 1'b1
    } disp_state_t;
endpackage

// File: rtl/ipa_hi_enc.sv
`timescale 1ns/1ps
// Highest-set-bit encoder.
module ipa_hi_enc #(
    parameter int W = 256
) (
    input  logic [W-1:0]         bits,
    output logic                 any,
    output logic [$clog2(W)-1:0] idx
);
    localparam int IW = $clog2(W);

    always_comb begin
        any = |bits;
        idx = '0;
        for (int i = 0; i < W; i++) begin
            if (bits[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/ipa_req_latch.sv
`timescale 1ns/1ps
// Pending register with per-class holding limit and overflow detection.
module ipa_req_latch #(
    parameter int VEC_W     = 8,
    parameter int CLS_W     = 4,
    parameter int RSV_LIMIT = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    loc_valid,
    input  logic [VEC_W-1:0]        loc_vec,
    input  logic                    ext_valid,
    input  logic [VEC_W-1:0]        ext_vec,
    input  logic                    clr_en,
    input  logic [VEC_W-1:0]        clr_vec,
    output logic [(1<<VEC_W)-1:0]   irr,
    output logic                    ovf
);
    localparam int NUM_VEC = 1 << VEC_W;
    localparam int NUM_CLS = 1 << CLS_W;
    localparam int PER_CLS = NUM_VEC / NUM_CLS;
    localparam logic [VEC_W-1:0] RSV_L = VEC_W'(RSV_LIMIT);

    logic [NUM_VEC-1:0] irr_r, irr_eff, clr_mask, set_mask;
    logic [NUM_CLS-1:0] cls_busy;
    logic [CLS_W-1:0]   l_cls, e_cls;
    logic l_ok, l_dup, l_take, l_ovf;
    logic e_ok, e_dup, e_busy, e_take, e_ovf;

    always_comb begin
        clr_mask = '0;
        if (clr_en) clr_mask[clr_vec] = 1'b1;
        irr_eff = irr_r & ~clr_mask;
    end

    for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
        assign cls_busy[c] = |irr_eff[c*PER_CLS +: PER_CLS];
    end

    always_comb begin
        l_cls  = loc_vec[VEC_W-1 -: CLS_W];
        e_cls  = ext_vec[VEC_W-1 -: CLS_W];
        l_ok   = loc_valid && (loc_vec >= RSV_L);
        l_dup  = irr_eff[loc_vec];
        l_take = l_ok && !l_dup && !cls_busy[l_cls];
        l_ovf  = l_ok && !l_dup &&  cls_busy[l_cls];
        e_ok   = ext_valid && (ext_vec >= RSV_L);
        e_dup  = irr_eff[ext_vec] || (l_take && (ext_vec == loc_vec));
        e_busy = cls_busy[e_cls] || (l_take && (e_cls == l_cls));
        e_take = e_ok && !e_dup && !e_busy;
        e_ovf  = e_ok && !e_dup &&  e_busy;
        set_mask = '0;
        if (l_take) set_mask[loc_vec] = 1'b1;
        if (e_take) set_mask[ext_vec] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irr_r <= '0;
            ovf   <= 1'b0;
        end else begin
            irr_r <= irr_eff | set_mask;
            ovf   <= l_ovf | e_ovf;
        end
    end

    assign irr = irr_r;
endmodule

// File: rtl/ipa_svc_track.sv
`timescale 1ns/1ps
// In-service register: set on grant, highest bit retired on end of interrupt.
module ipa_svc_track #(
    parameter int VEC_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  set_en,
    input  logic [VEC_W-1:0]      set_vec,
    input  logic                  eoi,
    output logic [(1<<VEC_W)-1:0] isr,
    output logic                  top_any,
    output logic [VEC_W-1:0]      top_vec
);
    localparam int NUM_VEC = 1 << VEC_W;

    logic [NUM_VEC-1:0] isr_r, set_mask, eoi_mask;

    ipa_hi_enc #(.W(NUM_VEC)) u_top (
        .bits (isr_r),
        .any  (top_any),
        .idx  (top_vec)
    );

    always_comb begin
        set_mask = '0;
        eoi_mask = '0;
        if (set_en)           set_mask[set_vec] = 1'b1;
        if (eoi && top_any)   eoi_mask[top_vec] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) isr_r <= '0;
        else        isr_r <= (isr_r & ~eoi_mask) | set_mask;
    end

    assign isr = isr_r;
endmodule

// File: rtl/ipa_dispatch.sv
`timescale 1ns/1ps
// Offer state machine: ST_SCAN looks for an eligible candidate, ST_OFFER holds it until acknowledge.
module ipa_dispatch
    import ipa_pkg::*;
#(
    parameter int VEC_W = 8,
    parameter int CLS_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cand_any,
    input  logic [VEC_W-1:0] cand_vec,
    input  logic [CLS_W-1:0] tpr_cls,
    input  logic             svc_any,
    input  logic [CLS_W-1:0] svc_cls,
    input  logic             int_ack,
    output logic             int_req,
    output logic [VEC_W-1:0] int_vector,
    output logic             grant
);
    disp_state_t      state_q, state_d;
    logic [VEC_W-1:0] vec_q;
    logic [CLS_W-1:0] cand_cls;
    logic             go;

    always_comb begin
        cand_cls = cand_vec[VEC_W-1 -: CLS_W];
        go       = cand_any && (cand_cls > tpr_cls) && (!svc_any || (cand_cls > svc_cls));
        state_d  = state_q;
        unique case (state_q)
            ST_SCAN:  if (go)      state_d = ST_OFFER;
            ST_OFFER: if (int_ack) state_d = ST_SCAN;
            default:               state_d = ST_SCAN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_SCAN;
            vec_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_SCAN && go) vec_q <= cand_vec;
        end
    end

    always_comb begin
        int_req    = (state_q == ST_OFFER);
        int_vector = vec_q;
        grant      = int_req && int_ack;
    end
endmodule

// File: rtl/ipa_accept_top.sv
`timescale 1ns/1ps
module ipa_accept_top #(
    parameter int VEC_W     = 8,
    parameter int CLS_W     = 4,
    parameter int RSV_LIMIT = 32,
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              loc_req_valid,
    input  logic [VEC_W-1:0]  loc_req_vector,
    input  logic              ext_req_valid,
    input  logic [VEC_W-1:0]  ext_req_vector,
    output logic              int_req,
    output logic [VEC_W-1:0]  int_vector,
    input  logic              int_ack,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr_en,
    input  logic [VEC_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              req_overflow
);
    localparam int NUM_VEC   = 1 << VEC_W;
    localparam int NUM_WORDS = NUM_VEC / DATA_W;
    localparam int WIDX      = $clog2(NUM_WORDS);
    localparam int SEL_LO    = 4 + WIDX;
    localparam logic [ADDR_W-1:0] TPR_OFS  = ADDR_W'(12'h080);
    localparam logic [ADDR_W-1:0] EOI_OFS  = ADDR_W'(12'h0B0);
    localparam logic [ADDR_W-1:0] ISR_BASE = ADDR_W'(12'h100);
    localparam logic [ADDR_W-1:0] IRR_BASE = ADDR_W'(12'h200);

    logic [NUM_VEC-1:0] irr_q, isr_q;
    logic [VEC_W-1:0]   tpr_q, cand_vec, svc_vec, grant_vec;
    logic               cand_any, svc_any, grant, eoi_hit;
    logic [WIDX-1:0]    word_sel;
    logic               isr_hit, irr_hit;

    ipa_req_latch #(.VEC_W(VEC_W), .CLS_W(CLS_W), .RSV_LIMIT(RSV_LIMIT)) u_req (
        .clk       (clk),
        .rst_n     (rst_n),
        .loc_valid (loc_req_valid),
        .loc_vec   (loc_req_vector),
        .ext_valid (ext_req_valid),
        .ext_vec   (ext_req_vector),
        .clr_en    (grant),
        .clr_vec   (grant_vec),
        .irr       (irr_q),
        .ovf       (req_overflow)
    );

    ipa_hi_enc #(.W(NUM_VEC)) u_cand (
        .bits (irr_q),
        .any  (cand_any),
        .idx  (cand_vec)
    );

    ipa_svc_track #(.VEC_W(VEC_W)) u_svc (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (grant),
        .set_vec (grant_vec),
        .eoi     (eoi_hit),
        .isr     (isr_q),
        .top_any (svc_any),
        .top_vec (svc_vec)
    );

    ipa_dispatch #(.VEC_W(VEC_W), .CLS_W(CLS_W)) u_disp (
        .clk        (clk),
        .rst_n      (rst_n),
        .cand_any   (cand_any),
        .cand_vec   (cand_vec),
        .tpr_cls    (tpr_q[VEC_W-1 -: CLS_W]),
        .svc_any    (svc_any),
        .svc_cls    (svc_vec[VEC_W-1 -: CLS_W]),
        .int_ack    (int_ack),
        .int_req    (int_req),
        .int_vector (int_vector),
        .grant      (grant)
    );

    assign grant_vec = int_vector;
    assign eoi_hit   = reg_wr_en && (reg_addr == EOI_OFS);

    always_ff @(posedge clk) begin
        if (!rst_n)                              tpr_q <= '0;
        else if (reg_wr_en && reg_addr == TPR_OFS) tpr_q <= reg_wdata;
    end

    // Word windows are aligned to NUM_WORDS*16 bytes; low nibble must be zero.
    always_comb begin
        word_sel  = reg_addr[SEL_LO-1:4];
        isr_hit   = (reg_addr[ADDR_W-1:SEL_LO] == ISR_BASE[ADDR_W-1:SEL_LO]) && (reg_addr[3:0] == 4'h0);
        irr_hit   = (reg_addr[ADDR_W-1:SEL_LO] == IRR_BASE[ADDR_W-1:SEL_LO]) && (reg_addr[3:0] == 4'h0);
        reg_rdata = '0;
        if (reg_addr == TPR_OFS) reg_rdata = DATA_W'(tpr_q);
        else if (isr_hit)        reg_rdata = isr_q[int'(word_sel)*DATA_W +: DATA_W];
        else if (irr_hit)        reg_rdata = irr_q[int'(word_sel)*DATA_W +: DATA_W];
    end
endmodule

// File: rtl/ipa_accept_chk.sv
`timescale 1ns/1ps
module ipa_accept_chk #(
    parameter int VEC_W     = 8,
    parameter int CLS_W     = 4,
    parameter int RSV_LIMIT = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [(1<<VEC_W)-1:0] irr,
    input logic [(1<<VEC_W)-1:0] isr,
    input logic [VEC_W-1:0]      tpr,
    input logic                  int_req,
    input logic [VEC_W-1:0]      int_vector,
    input logic                  int_ack,
    input logic                  eoi_wr
);
    localparam int NUM_CLS = 1 << CLS_W;
    localparam int PER_CLS = (1 << VEC_W) / NUM_CLS;

    logic [CLS_W-1:0] tpr_cls, vec_cls;
    assign tpr_cls = tpr[VEC_W-1 -: CLS_W];
    assign vec_cls = int_vector[VEC_W-1 -: CLS_W];

    p_no_reserved_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (irr[RSV_LIMIT-1:0] == '0) && (isr[RSV_LIMIT-1:0] == '0));

    for (genvar c = 0; c < NUM_CLS; c++) begin : g_lim
        p_one_pending_r3: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(irr[c*PER_CLS +: PER_CLS]) <= 1);
    end

    p_tpr_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_req) |-> (vec_cls > $past(tpr_cls)));

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (int_req && !int_ack) |=> (int_req && $stable(int_vector)));

    p_ack_moves_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (int_req && int_ack) |=> (!int_req && isr[$past(int_vector)]));

    p_eoi_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_wr && (isr == '0) && !(int_req && int_ack)) |=> (isr == '0));
endmodule

bind ipa_accept_top ipa_accept_chk #(
    .VEC_W(VEC_W), .CLS_W(CLS_W), .RSV_LIMIT(RSV_LIMIT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .irr        (irr_q),
    .isr        (isr_q),
    .tpr        (tpr_q),
    .int_req    (int_req),
    .int_vector (int_vector),
    .int_ack    (int_ack),
    .eoi_wr     (eoi_hit)
);

// File: tb/tb_ipa_accept_top.sv
`timescale 1ns/1ps
module tb_ipa_accept_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        loc_req_valid = 1'b0;
    logic [7:0]  loc_req_vector = '0;
    logic        ext_req_valid = 1'b0;
    logic [7:0]  ext_req_vector = '0;
    logic        int_req;
    logic [7:0]  int_vector;
    logic        int_ack = 1'b0;
    logic [11:0] reg_addr = '0;
    logic        reg_wr_en = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        req_overflow;

    int tests = 0;
    int fails = 0;

    ipa_accept_top dut (
        .clk(clk), .rst_n(rst_n),
        .loc_req_valid(loc_req_valid), .loc_req_vector(loc_req_vector),
        .ext_req_valid(ext_req_valid), .ext_req_vector(ext_req_vector),
        .int_req(int_req), .int_vector(int_vector), .int_ack(int_ack),
        .reg_addr(reg_addr), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .req_overflow(req_overflow)
    );

    always #10 clk = ~clk;

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.1;
        d = reg_rdata;
    endtask

    task automatic wr(input logic [11:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
        tick();
        reg_wr_en = 1'b0;
    endtask

    task automatic req_l(input logic [7:0] v);
        loc_req_valid = 1'b1; loc_req_vector = v;
        tick();
        loc_req_valid = 1'b0;
    endtask

    task automatic req_e(input logic [7:0] v);
        ext_req_valid = 1'b1; ext_req_vector = v;
        tick();
        ext_req_valid = 1'b0;
    endtask

    task automatic req_both(input logic [7:0] lv, input logic [7:0] ev);
        loc_req_valid = 1'b1; loc_req_vector = lv;
        ext_req_valid = 1'b1; ext_req_vector = ev;
        tick();
        loc_req_valid = 1'b0; ext_req_valid = 1'b0;
    endtask

    task automatic ack();
        int_ack = 1'b1;
        tick();
        int_ack = 1'b0;
    endtask

    task automatic eoi();
        wr(12'h0B0, 8'h00);
    endtask

    task automatic wait_req();
        for (int k = 0; k < 6 && !int_req; k++) tick();
    endtask

    function automatic logic [11:0] isr_a(input int v);
        return 12'h100 + 12'((v / 32) * 16);
    endfunction

    function automatic logic [11:0] irr_a(input int v);
        return 12'h200 + 12'((v / 32) * 16);
    endfunction

    initial begin
        logic [31:0] d;
        repeat (3) tick();
        rst_n = 1'b1;
        // R9 reset state
        chk("R9 int_req after reset", 32'(int_req), 0);
        chk("R9 overflow after reset", 32'(req_overflow), 0);
        rd(12'h080, d); chk("R9 task priority after reset", d, 0);
        for (int w = 0; w < 8; w++) begin
            rd(12'(12'h100 + w * 16), d); chk("R9 in-service word after reset", d, 0);
            rd(12'(12'h200 + w * 16), d); chk("R9 pending word after reset", d, 0);
        end

        // Sweep every vector alone: R1 R2 R4 R6 R7 R8
        for (int v = 0; v < 256; v++) begin
            logic [31:0] bitv;
            bitv = 32'(1) << (v % 32);
            req_l(8'(v));
            rd(irr_a(v), d);
            chk(v < 32 ? "R1 reserved not latched" : "R2 pending bit set", d, v < 32 ? 0 : bitv);
            chk("R1 R3 no overflow for single request", 32'(req_overflow), 0);
            tick();
            chk("R4 offer for single vector", 32'(int_req), v < 32 ? 0 : 1);
            if (v >= 32) begin
                chk("R4 offered vector", 32'(int_vector), 32'(v));
                ack();
                chk("R6 int_req drops after ack", 32'(int_req), 0);
                rd(isr_a(v), d); chk("R6 R8 in-service bit set", d, bitv);
                rd(irr_a(v), d); chk("R6 pending bit cleared", d, 0);
                eoi();
                rd(isr_a(v), d); chk("R7 in-service cleared by eoi", d, 0);
            end
        end

        // Threshold sweep: R4 R5
        for (int t = 0; t < 16; t++) begin
            for (int c = 2; c < 16; c++) begin
                wr(12'h080, 8'(t << 4));
                req_l(8'((c << 4) | 9));
                tick();
                chk(t == 15 ? "R5 class 15 threshold blocks" : "R4 threshold gate",
                    32'(int_req), (c > t) ? 1 : 0);
                wr(12'h080, 8'h00);
                wait_req();
                chk("R4 drained vector", 32'(int_vector), 32'((c << 4) | 9));
                ack();
                eoi();
            end
        end

        // Nesting: R10 R7
        req_l(8'h45); tick();
        chk("R10 first vector offered", 32'(int_vector), 32'h45);
        ack();
        req_l(8'h47); tick(); tick();
        chk("R10 same class waits", 32'(int_req), 0);
        req_l(8'h83); tick();
        chk("R10 higher class preempts", 32'(int_req), 1);
        chk("R10 higher class vector", 32'(int_vector), 32'h83);
        ack();
        rd(12'h140, d); chk("R10 nested in-service upper", d, 32'h8);
        rd(12'h120, d); chk("R10 nested in-service lower", d, 32'h20);
        eoi();
        rd(12'h140, d); chk("R7 eoi retires highest", d, 0);
        rd(12'h120, d); chk("R7 eoi leaves lower", d, 32'h20);
        tick();
        chk("R10 same class still waits", 32'(int_req), 0);
        eoi();
        rd(12'h120, d); chk("R7 second eoi", d, 0);
        tick();
        chk("R10 waiting vector offered after eoi", 32'(int_vector), 32'h47);
        chk("R10 waiting vector req", 32'(int_req), 1);
        ack(); eoi();

        // Overflow and merging: R3 R2
        wr(12'h080, 8'hF0);
        req_l(8'h50);
        chk("R3 first in class no overflow", 32'(req_overflow), 0);
        req_l(8'h51);
        chk("R3 second in class overflows", 32'(req_overflow), 1);
        rd(12'h220, d); chk("R3 dropped vector absent", d, 32'h0001_0000);
        tick();
        chk("R3 overflow is one cycle", 32'(req_overflow), 0);
        req_l(8'h50);
        chk("R2 duplicate merges without overflow", 32'(req_overflow), 0);
        req_both(8'h60, 8'h61);
        chk("R3 same-cycle pair overflows", 32'(req_overflow), 1);
        rd(12'h230, d); chk("R3 local kept in same-cycle pair", d, 32'h0000_0001);
        req_both(8'h70, 8'h70);
        chk("R2 same vector both ports merges", 32'(req_overflow), 0);
        rd(12'h230, d); chk("R2 merged vector latched", d, 32'h0001_0001);
        req_e(8'h90);
        rd(12'h240, d); chk("R2 external port latches", d, 32'h0001_0000);
        req_e(8'h10);
        chk("R1 reserved on external no overflow", 32'(req_overflow), 0);
        rd(12'h200, d); chk("R1 reserved on external not latched", d, 0);

        // R7 eoi with empty in-service; R6 stray ack
        eoi();
        rd(12'h220, d); chk("R7 empty eoi keeps pending", d, 32'h0001_0000);
        rd(12'h120, d); chk("R7 empty eoi keeps in-service empty", d, 0);
        ack();
        rd(12'h240, d); chk("R6 ack without offer ignored", d, 32'h0001_0000);
        rd(12'h140, d); chk("R6 ack without offer sets nothing", d, 0);

        // Drain in priority order: R4
        wr(12'h080, 8'h00);
        begin
            logic [7:0] order [4] = '{8'h90, 8'h70, 8'h60, 8'h50};
            for (int k = 0; k < 4; k++) begin
                wait_req();
                chk("R4 drain order", 32'(int_vector), 32'(order[k]));
                ack(); eoi();
            end
        end
        tick(); tick();
        chk("R4 nothing left to offer", 32'(int_req), 0);

        // Stability while offered: R6
        req_l(8'h40); tick();
        chk("R6 offer 0x40", 32'(int_vector), 32'h40);
        req_l(8'hF0); tick(); tick();
        chk("R6 held vector stable", 32'(int_vector), 32'h40);
        chk("R6 held request high", 32'(int_req), 1);
        ack(); tick();
        chk("R6 next offer is higher class", 32'(int_vector), 32'hF0);
        ack(); eoi(); eoi();
        rd(12'h120, d); chk("R7 both retired low", d, 0);
        rd(12'h170, d); chk("R7 both retired high", d, 0);

        // Register map: R8
        wr(12'h080, 8'h5A);
        rd(12'h080, d); chk("R8 task priority readback", d, 32'h5A);
        rd(12'h104, d); chk("R8 unaligned reads zero", d, 0);
        rd(12'h300, d); chk("R8 unmapped reads zero", d, 0);
        wr(12'h100, 8'hFF);
        rd(12'h100, d); chk("R8 word write ignored", d, 0);
        wr(12'h080, 8'h00);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule